// File: doc/BRIEF.md
# Dual-Coding Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output wire. A frame is a start bit, the data bits least significant first, an optional parity bit, and one or two stop bits. Each frame goes out in one of two line codings, picked per word: plain level coding, where a bit holds one level for its whole period, or Manchester coding, where each bit has a level change at its centre.

A producer presents a word on a valid/ready handshake together with the frame settings: data width, stop count, parity kind, coding and baud divisor. The block takes all of them at the clock edge of acceptance. A prescaler makes a baud tick every `cfg_div + 1` clocks. Sixteen ticks form one bit, and each bit is split into two halves of eight ticks, so a Manchester mid-bit edge falls exactly at the centre.

Top module: `ser_frame_tx`

## Requirements
- R1: `in_ready` is high when no frame is in flight. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low from the next cycle until the last half of the final stop bit has elapsed, and it rises in the cycle right after that.
- R2: A baud tick occurs every `cfg_div + 1` clocks and a bit lasts 16 ticks. Each half-bit therefore lasts `8 * (cfg_div + 1)` clocks. The first half of the start bit is on `tx` from the cycle after acceptance.
- R3: Bit order is: a start bit of value 0, then the data bits starting with `in_data[0]`, then parity if enabled, then the stop bits of value 1.
- R4: `cfg_size` values 5, 6, 7 and 8 send that many data bits. Any other code sends 8.
- R5: `cfg_two_stop = 1` sends two stop bits. `cfg_two_stop = 0` sends one.
- R6: `cfg_par` 2'b10 adds an even parity bit, equal to the XOR of the sent data bits. 2'b11 adds that XOR inverted (odd parity). 2'b00 and 2'b01 add no parity bit.
- R7: With `cfg_manch = 0`, both halves of every bit carry the bit's value.
- R8: With `cfg_manch = 1`, a 1 is sent low then high and a 0 is sent high then low. This holds for the start, data and stop bits alike.
- R9: With `cfg_manch = 1`, no parity bit is sent, whatever `cfg_par` holds.
- R10: `tx` is high whenever no frame is in flight. Changes to `in_data` or the configuration inputs during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can take a word |
| in_data | input | MAX_DATA (8) | Character, bit 0 sent first |
| cfg_size | input | 4 | Data-width code |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_par | input | 2 | Parity kind: 00/01 none, 10 even, 11 odd |
| cfg_manch | input | 1 | 1 = Manchester coding, 0 = level coding |
| cfg_div | input | DIV_W (12) | Baud divisor; tick period is cfg_div+1 clocks |
| tx | output | 1 | Serial line |

## Verification
A shift register that drops or repeats a bit, or a frame length counted wrongly, appears at the line as a wrong level in some half-bit. It also moves the rise of `in_ready` by a whole bit, which is two half-bit periods. A fault in the half-bit phase shows within one half-bit as a missing or extra mid-bit edge in Manchester, or a mid-bit edge in level coding. A divisor fault stretches or shrinks every half-bit and drifts the sample points off within the first bit of the frame.

// File: rtl/sft_pkg.sv
package sft_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_RSVD = 2'b01,
      PAR_EVEN = 2'b10,
      PAR_ODD  = 2'b11
   } par_mode_e;

endpackage

// File: rtl/sft_baud_gen.sv
// Prescaler plus half-bit phase counter; counts only while a frame runs.
module sft_baud_gen #(
   parameter int DIV_W = 12,
   parameter int OVS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             half_done
);
   localparam int HALF  = OVS / 2;
   localparam int SUB_W = (HALF > 1) ? $clog2(HALF) : 1;

   logic [DIV_W-1:0] presc_q;
   logic [SUB_W-1:0] sub_q;
   logic             tick;

   assign tick      = run && (presc_q == div);
   assign half_done = tick && (sub_q == SUB_W'(HALF - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         presc_q <= '0;
         sub_q   <= '0;
      end else begin
         if (tick) begin
            presc_q <= '0;
            sub_q   <= (sub_q == SUB_W'(HALF - 1)) ? '0 : sub_q + SUB_W'(1);
         end else begin
            presc_q <= presc_q + DIV_W'(1);
         end
      end
   end

   a_r2_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> presc_q <= div);

   a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      half_done && run |=> sub_q == '0 && presc_q == '0);

endmodule

// File: rtl/sft_frame_build.sv
// Builds the whole frame as a bit vector (bit 0 first on the line) and its length.
module sft_frame_build
   import sft_pkg::*;
#(
   parameter int MAX_DATA = 8,
   parameter int MIN_DATA = 5,
   parameter int FRAME_W  = 12,
   parameter int CNT_W    = 4
) (
   input  logic [MAX_DATA-1:0] data,
   input  logic [3:0]          size_code,
   input  logic                two_stop,
   input  par_mode_e           par,
   input  logic                manch,
   output logic [FRAME_W-1:0]  bits,
   output logic [CNT_W-1:0]    nbits
);
   localparam int WW = $clog2(MAX_DATA + 1);
   localparam int IW = $clog2(FRAME_W);

   logic [WW-1:0]       width;
   logic [MAX_DATA-1:0] mask;
   logic                par_on;
   logic                par_bit;
   logic [IW-1:0]       par_idx;

   always_comb begin
      if (size_code >= 4'(MIN_DATA) && size_code <= 4'(MAX_DATA))
         width = WW'(size_code);
      else
         width = WW'(MAX_DATA);
   end

   for (genvar gi = 0; gi < MAX_DATA; gi++) begin : g_mask
      assign mask[gi] = (width > WW'(gi));
   end

   assign par_on  = !manch && (par == PAR_EVEN || par == PAR_ODD);
   assign par_bit = (^(data & mask)) ^ (par == PAR_ODD);
   assign par_idx = IW'(width) + IW'(1);

   always_comb begin
      bits    = '1;
      bits[0] = 1'b0;
      for (int i = 0; i < MAX_DATA; i++) begin
         if (mask[i]) bits[1 + i] = data[i];
      end
      if (par_on) bits[par_idx] = par_bit;
      nbits = CNT_W'(width) + CNT_W'(2) + CNT_W'(par_on) + CNT_W'(two_stop);
   end

endmodule

// File: rtl/sft_line_coder.sv
// Maps the current bit and half-bit phase to the line level.
module sft_line_coder #(
   parameter bit MANCH_EN = 1'b1
) (
   input  logic active,
   input  logic bit_val,
   input  logic second_half,
   input  logic manch,
   output logic line
);
   if (MANCH_EN) begin : g_dual
      always_comb begin
         if (!active)     line = 1'b1;
         else if (manch)  line = second_half ? bit_val : ~bit_val;
         else             line = bit_val;
      end
   end else begin : g_level_only
      logic unused_in;
      assign unused_in = manch ^ second_half;
      assign line      = active ? bit_val : 1'b1;
   end

endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
   import sft_pkg::*;
#(
   parameter int MAX_DATA = 8,
   parameter int MIN_DATA = 5,
   parameter int DIV_W    = 12,
   parameter int OVS      = 16,
   parameter bit MANCH_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [MAX_DATA-1:0] in_data,
   input  logic [3:0]          cfg_size,
   input  logic                cfg_two_stop,
   input  logic [1:0]          cfg_par,
   input  logic                cfg_manch,
   input  logic [DIV_W-1:0]    cfg_div,
   output logic                tx
);
   localparam int FRAME_W = MAX_DATA + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam int MIN_LEN = MIN_DATA + 2;

   if (MAX_DATA > 15 || MIN_DATA < 1 || MIN_DATA > MAX_DATA) begin : g_bad_width
      $error("ser_frame_tx: data width range out of bounds");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("ser_frame_tx: oversampling must be even and at least 4");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("ser_frame_tx: divisor width must be positive");
   end

   logic                busy_q;
   logic                half_q;
   logic                man_q;
   logic [DIV_W-1:0]    div_q;
   logic [FRAME_W-1:0]  frame_q;
   logic [CNT_W-1:0]    left_q;
   logic [FRAME_W-1:0]  built_bits;
   logic [CNT_W-1:0]    built_len;
   logic                half_done;
   logic                accept;

   assign in_ready = !busy_q;
   assign accept   = in_valid && !busy_q;

   sft_frame_build #(
      .MAX_DATA (MAX_DATA),
      .MIN_DATA (MIN_DATA),
      .FRAME_W  (FRAME_W),
      .CNT_W    (CNT_W)
   ) u_build (
      .data      (in_data),
      .size_code (cfg_size),
      .two_stop  (cfg_two_stop),
      .par       (par_mode_e'(cfg_par)),
      .manch     (cfg_manch && MANCH_EN),
      .bits      (built_bits),
      .nbits     (built_len)
   );

   sft_baud_gen #(
      .DIV_W (DIV_W),
      .OVS   (OVS)
   ) u_baud (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy_q),
      .div       (div_q),
      .half_done (half_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         half_q  <= 1'b0;
         man_q   <= 1'b0;
         div_q   <= '0;
         frame_q <= '1;
         left_q  <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         half_q  <= 1'b0;
         man_q   <= cfg_manch && MANCH_EN;
         div_q   <= cfg_div;
         frame_q <= built_bits;
         left_q  <= built_len;
      end else if (busy_q && half_done) begin
         if (!half_q) begin
            half_q <= 1'b1;
         end else begin
            half_q  <= 1'b0;
            frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            left_q  <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) busy_q <= 1'b0;
         end
      end
   end

   sft_line_coder #(
      .MANCH_EN (MANCH_EN)
   ) u_coder (
      .active      (busy_q),
      .bit_val     (frame_q[0]),
      .second_half (half_q),
      .manch       (man_q),
      .line        (tx)
   );

   // R1: the handshake only drops on a real acceptance
   a_r1_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> $past(in_valid));

   // R1: ready returns only at the end of a second half-bit
   a_r1_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> $past(half_done && half_q));

   // R2: the line holds between half-bit boundaries
   a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !half_done |=> $stable(tx));

   // R3: a freshly loaded frame begins with a low start bit and a sane length
   a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> frame_q[0] == 1'b0 && left_q >= CNT_W'(MIN_LEN));

   // R7: no mid-bit edge in level coding
   a_r7_level_flat: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !man_q && half_done && !half_q |=> $stable(tx));

   // R8: a mid-bit edge on every Manchester bit
   a_r8_mid_edge: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && man_q && half_done && !half_q |=> tx != $past(tx));

   // R10: idle line is high
   a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> tx);

endmodule

// File: tb/sim_ser_frame_tx.sv
`timescale 1ns/1ps
module sim_ser_frame_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic [3:0]  cfg_size = 4'd8;
   logic        cfg_two_stop = 1'b0;
   logic [1:0]  cfg_par = 2'b00;
   logic        cfg_manch = 1'b0;
   logic [11:0] cfg_div = '0;
   logic        tx;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit mon_busy = 1'b0;
   bit done = 1'b0;

   logic  exp_q[$];
   int    len_q[$];
   int    h_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   ser_frame_tx u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_data      (in_data),
      .cfg_size     (cfg_size),
      .cfg_two_stop (cfg_two_stop),
      .cfg_par      (cfg_par),
      .cfg_manch    (cfg_manch),
      .cfg_div      (cfg_div),
      .tx           (tx)
   );

   task automatic check(input string tag, input logic got, input logic exp, input string what);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // Driver: computes the expected half-bit levels, queues them, then offers the word.
   task automatic send(input string tag, input logic [7:0] d, input logic [3:0] sz,
                       input logic two, input logic [1:0] par, input logic man, input int div);
      int w;
      logic b[$];
      logic px;
      w = (sz >= 4'd5 && sz <= 4'd8) ? int'(sz) : 8;
      b.push_back(1'b0);
      px = 1'b0;
      for (int i = 0; i < w; i++) begin
         b.push_back(d[i]);
         px = px ^ d[i];
      end
      if (!man && par[1]) b.push_back(px ^ par[0]);
      b.push_back(1'b1);
      if (two) b.push_back(1'b1);
      foreach (b[i]) begin
         if (man) begin
            exp_q.push_back(~b[i]);
            exp_q.push_back(b[i]);
         end else begin
            exp_q.push_back(b[i]);
            exp_q.push_back(b[i]);
         end
      end
      len_q.push_back(2 * b.size());
      h_q.push_back(8 * (div + 1));
      tag_q.push_back(tag);
      @(posedge clk); #1;
      in_data      = d;
      cfg_size     = sz;
      cfg_two_stop = two;
      cfg_par      = par;
      cfg_manch    = man;
      cfg_div      = 12'(div);
      in_valid     = 1'b1;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      // scramble inputs during the frame: must have no effect (R10)
      in_data  = ~d;
      cfg_size = 4'd5;
      cfg_manch = ~man;
      cfg_div  = 12'd1;
      cfg_par  = ~par;
   endtask

   // Monitor: pops the expected frame when an acceptance is seen and samples mid half-bit.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && in_valid && in_ready) begin
            int n;
            int h;
            string tag;
            mon_busy = 1'b1;
            if (len_q.size() == 0) begin
               n_tests++;
               n_fail++;
               $display("FAIL R1 unexpected acceptance: got 1 expected 0");
               n = 0; h = 8; tag = "R1";
            end else begin
               n = len_q.pop_front();
               h = h_q.pop_front();
               tag = tag_q.pop_front();
            end
            @(posedge clk);
            for (int k = 0; k < n; k++) begin
               logic e;
               repeat (h / 2) @(posedge clk);
               #1;
               e = exp_q.pop_front();
               check(tag, tx, e, $sformatf("R2/R3 half %0d line", k));
               check("R1", in_ready, 1'b0, $sformatf("ready low in half %0d", k));
               repeat (h - h / 2) @(posedge clk);
            end
            #1;
            check("R1", in_ready, 1'b1, "ready back after last stop half");
            check("R10", tx, 1'b1, "line high after frame");
            mon_busy = 1'b0;
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL R2 watchdog expired: got %0d cycles expected <= 150000", cycles);
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", in_ready, 1'b1, "ready after reset");
      check("R10", tx, 1'b1, "line idle after reset");
      repeat (5) @(negedge clk);
      check("R10", tx, 1'b1, "line stays idle");

      send("R3_R7",  8'hA5, 4'd8,  1'b0, 2'b00, 1'b0, 0);
      send("R4_5b",  8'hE6, 4'd5,  1'b0, 2'b00, 1'b0, 0);
      send("R4_6b",  8'h2D, 4'd6,  1'b0, 2'b00, 1'b0, 1);
      send("R4_7b",  8'h7B, 4'd7,  1'b0, 2'b00, 1'b0, 0);
      send("R4_c0",  8'h81, 4'd0,  1'b0, 2'b00, 1'b0, 0);
      send("R4_c15", 8'h3C, 4'd15, 1'b0, 2'b00, 1'b0, 0);
      send("R6_even",8'h07, 4'd8,  1'b0, 2'b10, 1'b0, 0);
      send("R6_odd", 8'h07, 4'd8,  1'b0, 2'b11, 1'b0, 0);
      send("R6_odd7",8'hC3, 4'd7,  1'b0, 2'b11, 1'b0, 0);
      send("R6_rsv", 8'h55, 4'd8,  1'b0, 2'b01, 1'b0, 0);
      send("R5_two", 8'h96, 4'd8,  1'b1, 2'b10, 1'b0, 0);
      send("R8",     8'h3C, 4'd8,  1'b0, 2'b00, 1'b1, 0);
      send("R8_R5",  8'hB1, 4'd6,  1'b1, 2'b00, 1'b1, 0);
      send("R9_odd", 8'h01, 4'd8,  1'b0, 2'b11, 1'b1, 0);
      send("R9_even",8'hF0, 4'd5,  1'b1, 2'b10, 1'b1, 2);
      send("R2_div", 8'h5A, 4'd8,  1'b1, 2'b11, 1'b0, 3);
      send("R2_R7",  8'h00, 4'd8,  1'b0, 2'b10, 1'b0, 5);

      wait (len_q.size() == 0 && !mon_busy);
      repeat (20) @(negedge clk);
      check("R1", in_ready, 1'b1, "ready at end");
      check("R10", tx, 1'b1, "line idle at end");
      if (exp_q.size() != 0) begin
         n_tests++;
         n_fail++;
         $display("FAIL R3 leftover half-bits: got %0d expected 0", exp_q.size());
      end
      done = 1'b1;
      summary();
   end

endmodule